// File: doc/BRIEF.md
# Link-Layer Sequencing and Replay Engine

This block is the reliability layer between a packet producer and a serial link. Its transmit half accepts packets from the layer above, stamps each with the next 12-bit sequence number, keeps a copy in a small replay store and sends it out on the link. Copies stay in the store until the far end acknowledges them. An acknowledge is cumulative and frees every copy up to the number it carries. A negative acknowledge also frees copies up to the number it carries, and then causes every later copy to be sent again, oldest first.

The receive half checks each incoming packet against the sequence number it expects and against a CRC-good flag computed elsewhere. A good packet in order is passed upward and acknowledged. A packet that repeats an old number is dropped, and the last good number is acknowledged again. A corrupt packet, or one that skips ahead, draws a single negative acknowledge that names the last good number. No further negative acknowledge is sent until the expected packet arrives. All sequence arithmetic is modulo 4096.

Top module: `dll_replay_engine`

## Requirements
- R1: Accepted packets receive consecutive sequence numbers. The first after reset is 0, and the count wraps from 4095 to 0.
- R2: A packet accepted at a clock edge appears on `tx_valid`/`tx_seq`/`tx_data` right after that edge, with its own data.
- R3: When DEPTH packets are unacknowledged, `up_ready` is low and an offered packet is neither sent nor numbered.
- R4: An acknowledge S (`fb_is_nak`=0) frees all stored packets up to and including S. An acknowledge whose modular distance past the last acknowledged number exceeds the outstanding count is ignored.
- R5: A negative acknowledge S (`fb_is_nak`=1) frees packets up to S. From the second edge after it, one stored packet per cycle is resent, from S+1 up to the newest, in order and with the original data. `up_ready` stays low until the last one has been sent.
- R6: A negative acknowledge that names the newest packet sends nothing again and acts as a full acknowledge.
- R7: A CRC-good packet carrying the expected number is forwarded on `dn_valid`/`dn_data` one edge later, together with an acknowledge (`msg_is_nak`=0) of that number. The expected number then advances by one, modulo 4096.
- R8: A packet with `rx_crc_ok`=0 produces a negative acknowledge (`msg_is_nak`=1) carrying the expected number minus one, and it is not forwarded.
- R9: A CRC-good packet whose number is 1 to 2047 ahead of the expected number is not forwarded and produces a negative acknowledge of the expected number minus one.
- R10: A CRC-good packet whose number is 1 to 2048 behind the expected number is dropped and re-acknowledged with the expected number minus one.
- R11: After a negative acknowledge, later errors produce no message until an in-order good packet arrives.
- R12: While reset is held and right after it, `tx_valid`, `dn_valid` and `msg_valid` are low and `up_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| up_valid | input | 1 | Upper layer offers a packet |
| up_data | input | DW | Offered packet payload |
| up_ready | output | 1 | Engine takes the offered packet at this edge |
| fb_valid | input | 1 | Acknowledge or negative acknowledge received from the far end |
| fb_is_nak | input | 1 | 1 = negative acknowledge, 0 = acknowledge |
| fb_seq | input | 12 | Sequence number carried by the feedback message |
| tx_valid | output | 1 | Packet on the link this cycle |
| tx_seq | output | 12 | Sequence number of the outgoing packet |
| tx_data | output | DW | Payload of the outgoing packet |
| rx_valid | input | 1 | Incoming packet present |
| rx_seq | input | 12 | Sequence number of the incoming packet |
| rx_data | input | DW | Payload of the incoming packet |
| rx_crc_ok | input | 1 | CRC check result for the incoming packet |
| dn_valid | output | 1 | Good packet forwarded upward |
| dn_data | output | DW | Forwarded payload |
| msg_valid | output | 1 | Outgoing acknowledge or negative acknowledge |
| msg_is_nak | output | 1 | 1 = negative acknowledge |
| msg_seq | output | 12 | Sequence number carried by the outgoing message |

## Verification
Every result except replay is registered once. A new packet appears on the link, a forwarded packet appears upward, and an acknowledge is returned, each right after the edge that captures the stimulus. A replay begins one edge later than that, because the negative acknowledge first loads the replay pointer. The bench drives all inputs on the falling edge and samples 1 ns after the next rising edge. For a replay it steps one idle cycle per resent packet, starting from the second rising edge after the negative acknowledge. Full sweeps across the 4096-value wrap on both halves check every number against a modulo count that the bench keeps itself.

// File: rtl/dllr_pkg.sv
package dllr_pkg;
  localparam int SEQ_W = 12;
  typedef logic [SEQ_W-1:0] seq_t;

  // modular forward distance from b to a
  function automatic seq_t seq_gap(input seq_t a, input seq_t b);
    return a - b;
  endfunction
endpackage

// File: rtl/dllr_rst_sync.sv
module dllr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dllr_replay_mem.sv
module dllr_replay_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DW-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) slot_q[i] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/dllr_tx.sv
module dllr_tx
  import dllr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  input  logic [DW-1:0] up_data,
  output logic          up_ready,
  input  logic          fb_valid,
  input  logic          fb_is_nak,
  input  seq_t          fb_seq,
  output logic          tx_valid,
  output seq_t          tx_seq,
  output logic [DW-1:0] tx_data
);
  localparam int   IDX_W   = $clog2(DEPTH);
  localparam seq_t DEPTH_S = seq_t'(DEPTH);

  seq_t          next_q, next_d;
  seq_t          ackd_q, ackd_d;
  seq_t          rp_q, rp_d;
  logic          rpl_q, rpl_d;
  logic          txv_q, txv_d;
  seq_t          txs_q, txs_d;
  logic [DW-1:0] txd_q, txd_d;
  logic          txd_en;

  seq_t          outst;
  logic          take;
  logic          fb_ok;
  logic          nak_hit;
  logic [DW-1:0] rd_data;

  dllr_replay_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .wr_en   (take),
    .wr_idx  (next_q[IDX_W-1:0]),
    .wr_data (up_data),
    .rd_idx  (rp_q[IDX_W-1:0]),
    .rd_data (rd_data)
  );

  always_comb begin
    outst    = seq_gap(next_q, ackd_q) - seq_t'(1);
    up_ready = !rpl_q && (outst < DEPTH_S);
    take     = up_valid && up_ready;
    fb_ok    = fb_valid && (seq_gap(fb_seq, ackd_q) <= outst);
    nak_hit  = fb_ok && fb_is_nak;

    next_d = take ? next_q + seq_t'(1) : next_q;
    ackd_d = fb_ok ? fb_seq : ackd_q;

    rp_d   = rp_q;
    rpl_d  = rpl_q;
    txv_d  = 1'b0;
    txs_d  = txs_q;
    txd_d  = txd_q;
    txd_en = 1'b0;

    if (take) begin
      txv_d  = 1'b1;
      txs_d  = next_q;
      txd_d  = up_data;
      txd_en = 1'b1;
    end else if (rpl_q && !nak_hit) begin
      txv_d  = 1'b1;
      txs_d  = rp_q;
      txd_d  = rd_data;
      txd_en = 1'b1;
      rp_d   = rp_q + seq_t'(1);
      rpl_d  = (rp_q + seq_t'(1)) != next_q;
    end

    if (nak_hit) begin
      rp_d  = fb_seq + seq_t'(1);
      rpl_d = (fb_seq + seq_t'(1)) != next_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
      ackd_q <= '1;
      rp_q   <= '0;
      rpl_q  <= 1'b0;
      txv_q  <= 1'b0;
      txs_q  <= '0;
    end else begin
      next_q <= next_d;
      ackd_q <= ackd_d;
      rp_q   <= rp_d;
      rpl_q  <= rpl_d;
      txv_q  <= txv_d;
      txs_q  <= txs_d;
    end
  end

  always_ff @(posedge clk) begin
    if (txd_en) txd_q <= txd_d;
  end

  assign tx_valid = txv_q;
  assign tx_seq   = txs_q;
  assign tx_data  = txd_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= DEPTH_S);

  assert_accept_emits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> (tx_valid && tx_seq == $past(next_q)));

  assert_nak_starts_replay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpl_q) |-> $past(fb_valid && fb_is_nak));

  assert_replay_in_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rpl_q && !fb_valid) |=> (tx_valid && tx_seq == $past(rp_q)));
endmodule

// File: rtl/dllr_rx.sv
module dllr_rx
  import dllr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  seq_t          rx_seq,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_crc_ok,
  output logic          dn_valid,
  output logic [DW-1:0] dn_data,
  output logic          msg_valid,
  output logic          msg_is_nak,
  output seq_t          msg_seq
);
  seq_t          exp_q, exp_d;
  logic          pend_q, pend_d;
  logic          dnv_q, dnv_d;
  logic [DW-1:0] dnd_q;
  logic          mv_q, mv_d;
  logic          mn_q, mn_d;
  seq_t          ms_q, ms_d;

  seq_t gap;
  seq_t last_good;
  logic good, dup, err, send_nak;

  always_comb begin
    gap       = seq_gap(rx_seq, exp_q);
    last_good = exp_q - seq_t'(1);
    good      = rx_valid && rx_crc_ok && (gap == '0);
    dup       = rx_valid && rx_crc_ok && gap[SEQ_W-1];
    err       = rx_valid && (!rx_crc_ok || ((gap != '0) && !gap[SEQ_W-1]));
    send_nak  = err && !pend_q;

    exp_d  = good ? exp_q + seq_t'(1) : exp_q;
    pend_d = good ? 1'b0 : (send_nak ? 1'b1 : pend_q);
    dnv_d  = good;

    mv_d = good || dup || send_nak;
    mn_d = send_nak;
    ms_d = good ? rx_seq : last_good;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= '0;
      pend_q <= 1'b0;
      dnv_q  <= 1'b0;
      mv_q   <= 1'b0;
      mn_q   <= 1'b0;
      ms_q   <= '0;
    end else begin
      exp_q  <= exp_d;
      pend_q <= pend_d;
      dnv_q  <= dnv_d;
      mv_q   <= mv_d;
      mn_q   <= mn_d;
      ms_q   <= ms_d;
    end
  end

  always_ff @(posedge clk) begin
    if (good) dnd_q <= rx_data;
  end

  assign dn_valid   = dnv_q;
  assign dn_data    = dnd_q;
  assign msg_valid  = mv_q;
  assign msg_is_nak = mn_q;
  assign msg_seq    = ms_q;

  assert_fwd_acked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (msg_valid && !msg_is_nak && msg_seq == $past(rx_seq)));

  assert_single_nak_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_is_nak) |=> !(msg_valid && msg_is_nak));

  assert_nak_not_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_crc_ok) |=> !dn_valid);
endmodule

// File: rtl/dll_replay_engine.sv
module dll_replay_engine
  import dllr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  input  logic [DW-1:0] up_data,
  output logic          up_ready,
  input  logic          fb_valid,
  input  logic          fb_is_nak,
  input  logic [11:0]   fb_seq,
  output logic          tx_valid,
  output logic [11:0]   tx_seq,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  input  logic [11:0]   rx_seq,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_crc_ok,
  output logic          dn_valid,
  output logic [DW-1:0] dn_data,
  output logic          msg_valid,
  output logic          msg_is_nak,
  output logic [11:0]   msg_seq
);
  logic rst_sync_n;

  dllr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dllr_tx #(.DW(DW), .DEPTH(DEPTH)) u_tx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .up_valid  (up_valid),
    .up_data   (up_data),
    .up_ready  (up_ready),
    .fb_valid  (fb_valid),
    .fb_is_nak (fb_is_nak),
    .fb_seq    (fb_seq),
    .tx_valid  (tx_valid),
    .tx_seq    (tx_seq),
    .tx_data   (tx_data)
  );

  dllr_rx #(.DW(DW)) u_rx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rx_valid   (rx_valid),
    .rx_seq     (rx_seq),
    .rx_data    (rx_data),
    .rx_crc_ok  (rx_crc_ok),
    .dn_valid   (dn_valid),
    .dn_data    (dn_data),
    .msg_valid  (msg_valid),
    .msg_is_nak (msg_is_nak),
    .msg_seq    (msg_seq)
  );
endmodule

// File: tb/sim_dll_replay_engine.sv
`timescale 1ns/1ps
module sim_dll_replay_engine;
  localparam int DW = 16;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic up_valid, up_ready, fb_valid, fb_is_nak;
  logic [DW-1:0] up_data, tx_data, rx_data, dn_data;
  logic [11:0] fb_seq, tx_seq, rx_seq, msg_seq;
  logic tx_valid, rx_valid, rx_crc_ok, dn_valid, msg_valid, msg_is_nak;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dll_replay_engine #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
    .fb_valid(fb_valid), .fb_is_nak(fb_is_nak), .fb_seq(fb_seq),
    .tx_valid(tx_valid), .tx_seq(tx_seq), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_seq(rx_seq), .rx_data(rx_data), .rx_crc_ok(rx_crc_ok),
    .dn_valid(dn_valid), .dn_data(dn_data),
    .msg_valid(msg_valid), .msg_is_nak(msg_is_nak), .msg_seq(msg_seq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one transmit-side cycle: drive on falling edge, sample after rising edge
  task automatic tcyc(input logic uv, input logic [DW-1:0] ud,
                      input logic fv, input logic fn, input logic [11:0] fs);
    @(negedge clk);
    up_valid = uv; up_data = ud; fb_valid = fv; fb_is_nak = fn; fb_seq = fs;
    @(posedge clk); #1;
  endtask

  task automatic rcyc(input logic v, input logic [11:0] s,
                      input logic [DW-1:0] d, input logic ok);
    @(negedge clk);
    rx_valid = v; rx_seq = s; rx_data = d; rx_crc_ok = ok;
    @(posedge clk); #1;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    up_valid = 0; up_data = '0; fb_valid = 0; fb_is_nak = 0; fb_seq = '0;
    rx_valid = 0; rx_seq = '0; rx_data = '0; rx_crc_ok = 0;
    repeat (3) @(posedge clk); #1;
    // R12 reset state
    chk("R12 tx_valid", tx_valid, 0);
    chk("R12 dn_valid", dn_valid, 0);
    chk("R12 msg_valid", msg_valid, 0);
    chk("R12 up_ready", up_ready, 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R12 up_ready after release", up_ready, 1);
    chk("R12 tx_valid after release", tx_valid, 0);

    // R1 R2 R3: fill the store
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 ready before fill", up_ready, 1);
      tcyc(1, 16'hA000 + 16'(i), 0, 0, 0);
      chk("R1 seq", tx_seq, i);
      chk("R2 valid", tx_valid, 1);
      chk("R2 data", tx_data, 16'hA000 + 16'(i));
    end
    chk("R3 full stall", up_ready, 0);
    tcyc(1, 16'hBEEF, 0, 0, 0);
    chk("R3 offered packet not sent", tx_valid, 0);

    // R4 cumulative ack, then stale ack
    tcyc(0, 0, 1, 0, 12'd2);
    chk("R4 ack frees", up_ready, 1);
    tcyc(0, 0, 1, 0, 12'd1);
    for (int i = 8; i < 11; i++) begin
      tcyc(1, 16'hA000 + 16'(i), 0, 0, 0);
      chk("R4 stale ack ignored, room kept", tx_valid, 1);
      chk("R1 seq", tx_seq, i);
    end
    chk("R3 full again", up_ready, 0);

    // R5 nak replay 6..10
    tcyc(0, 0, 1, 1, 12'd5);
    chk("R5 no send on nak edge", tx_valid, 0);
    chk("R5 ready low in replay", up_ready, 0);
    for (int k = 6; k <= 10; k++) begin
      tcyc(0, 0, 0, 0, 0);
      chk("R5 replay valid", tx_valid, 1);
      chk("R5 replay seq", tx_seq, k);
      chk("R5 replay data", tx_data, 16'hA000 + 16'(k));
    end
    chk("R5 ready after replay", up_ready, 1);
    tcyc(0, 0, 0, 0, 0);
    chk("R5 replay ended", tx_valid, 0);

    // R6 nak of newest packet
    tcyc(0, 0, 1, 1, 12'd10);
    tcyc(0, 0, 0, 0, 0);
    chk("R6 nothing resent", tx_valid, 0);
    chk("R6 ready", up_ready, 1);
    for (int i = 11; i < 11 + DEPTH; i++) begin
      tcyc(1, 16'hA000 + 16'(i), 0, 0, 0);
      chk("R6 full room after nak", tx_valid, 1);
      chk("R1 seq", tx_seq, i);
    end
    chk("R3 full", up_ready, 0);
    tcyc(0, 0, 1, 0, 12'd18);
    chk("R4 ack all", up_ready, 1);

    // R1 wrap sweep
    for (int s = 19; s < 4096 + 24; s++) begin
      tcyc(1, 16'(s) ^ 16'h5A5A, 0, 0, 0);
      chk("R1 wrap seq", tx_seq, s % 4096);
      chk("R2 wrap data", tx_data, 16'(s) ^ 16'h5A5A);
      tcyc(0, 0, 1, 0, 12'(s % 4096));
    end
    tcyc(0, 0, 0, 0, 0);

    // receive half
    for (int s = 0; s < 3; s++) begin
      rcyc(1, 12'(s), 16'hC000 + 16'(s), 1);
      chk("R7 fwd", dn_valid, 1);
      chk("R7 fwd data", dn_data, 16'hC000 + 16'(s));
      chk("R7 ack", {msg_valid, msg_is_nak}, 2'b10);
      chk("R7 ack seq", msg_seq, s);
    end
    rcyc(1, 12'd3, 16'h1111, 0);
    chk("R8 not fwd", dn_valid, 0);
    chk("R8 nak", {msg_valid, msg_is_nak}, 2'b11);
    chk("R8 nak seq", msg_seq, 2);
    rcyc(1, 12'd3, 16'h1111, 0);
    chk("R11 second bad silent", msg_valid, 0);
    rcyc(1, 12'd5, 16'h1111, 1);
    chk("R11 ahead silent", msg_valid, 0);
    chk("R9 ahead not fwd", dn_valid, 0);
    rcyc(1, 12'd3, 16'hC003, 1);
    chk("R11 good clears", {dn_valid, msg_valid, msg_is_nak}, 3'b110);
    chk("R7 ack seq", msg_seq, 3);
    rcyc(1, 12'd7, 16'h2222, 1);
    chk("R9 ahead nak", {dn_valid, msg_valid, msg_is_nak}, 3'b011);
    chk("R9 nak seq", msg_seq, 3);
    rcyc(1, 12'd4, 16'hC004, 1);
    chk("R7 fwd", dn_valid, 1);
    rcyc(1, 12'd1, 16'h3333, 1);
    chk("R10 dup dropped", {dn_valid, msg_valid, msg_is_nak}, 3'b010);
    chk("R10 re-ack seq", msg_seq, 4);

    // R7 wrap sweep
    for (int s = 5; s < 4096 + 4; s++) begin
      rcyc(1, 12'(s % 4096), 16'(s) ^ 16'h0F0F, 1);
      chk("R7 wrap fwd", dn_valid, 1);
      chk("R7 wrap data", dn_data, 16'(s) ^ 16'h0F0F);
      chk("R7 wrap ack", msg_seq, s % 4096);
    end
    rcyc(1, 12'd4090, 16'h4444, 1);
    chk("R10 dup across wrap", {dn_valid, msg_valid, msg_is_nak}, 3'b010);
    chk("R10 re-ack seq", msg_seq, 3);
    rcyc(1, 12'd4, 16'hC104, 1);
    chk("R7 after wrap", {dn_valid, msg_seq}, {1'b1, 12'd4});
    rcyc(0, 0, 0, 0);
    chk("R7 idle", {dn_valid, msg_valid}, 2'b00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule